// File: doc/BRIEF.md
# Split-Queue Used Ring Completion and Interrupt Unit

This unit retires finished request chains on one split virtqueue. For each completion command it stores an eight-byte used element (the chain's head id and the number of bytes the device wrote) into the used ring through a memory write port, and it advances a private next-used counter. Shared memory sees that counter only when a sync command arrives. The unit then writes the counter into the ring's used index field and decides whether the queue interrupt is raised or suppressed.

The interrupt decision uses two inputs. One is the driver's available-ring flag word, whose bit 0 asks the device not to interrupt. The other is the negotiated notify-on-empty feature, which overrides that request when the queue has run empty. A raised interrupt sets bit 0 of an interrupt status register and drives the interrupt line. A read-clear input drops both. Raised and suppressed decisions have separate counters. A third command performs a read-modify-write of the used ring flag word to turn driver notifications on or off.

Layout of the used ring, relative to `used_base`, with all fields little-endian (byte k of `mem_wdata` goes to `mem_addr + k`):
- offset 0: flags
- offset 2: used index
- offset 4 onward: elements, 8 bytes each

Top module: `uring_complete`

## Requirements
- R1: After reset `cmd_ready` is 1. `irq_line`, `isr`, both counters, `mem_wr` and `mem_rd` are all 0.
- R2: A completion accepted on `put_valid` produces exactly one write in the next cycle: 8 bytes at `used_base + 4 + 8*(n mod RING_SIZE)`, where n is the next-used count. `mem_wdata[31:0]` carries the head id and `mem_wdata[63:32]` the length. n then increments by one.
- R3: The used index field is written only for a sync command. The write is 2 bytes at `used_base + 2`, with `mem_wdata[15:0]` equal to the next-used count.
- R4: In the cycle after the index write, an interrupt is raised when bit 0 of `avail_flags` (no-interrupt) is 0. It is also raised when `feat_notify_empty` and `queue_empty` are both 1, whatever that bit holds. Raising sets `isr[0]`, drives `irq_line` to 1 and increments `raised_cnt`.
- R5: When the decision is to suppress, `skipped_cnt` increments and `isr` and `irq_line` keep their values.
- R6: A pulse on `isr_rd` clears `isr` and lowers `irq_line` one cycle later. If a raise falls in the same cycle, the raise wins.
- R7: A completion and a sync presented together write the element first and the index in the next cycle. The index value includes that element.
- R8: A notify command reads 2 bytes at `used_base` (`mem_rd`, answered by `mem_rvalid`/`mem_rdata`). It then writes the same word back to `used_base` with bit 0 (no-notify) cleared when `notif_enable` is 1 or set when it is 0. All other bits are unchanged.
- R9: `cmd_ready` is 0 while a sequence runs, and commands offered then are ignored. A notify command offered together with a completion or sync is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| used_base | input | AW | Byte address of the used ring |
| feat_notify_empty | input | 1 | Notify-on-empty feature negotiated |
| avail_flags | input | 16 | Driver's available-ring flags, bit 0 = no interrupt |
| queue_empty | input | 1 | Available ring holds no unconsumed entries |
| cmd_ready | output | 1 | Unit idle, commands accepted |
| put_valid | input | 1 | Completion command |
| put_id | input | 32 | Head descriptor id of the finished chain |
| put_len | input | 32 | Bytes written into the chain |
| sync_req | input | 1 | Publish index and decide interrupt |
| notif_req | input | 1 | Update the no-notify flag |
| notif_enable | input | 1 | 1 = enable notifications, 0 = disable |
| isr_rd | input | 1 | Read-clear of the interrupt status |
| isr | output | ISR_W | Interrupt status register, bit 0 = queue cause |
| irq_line | output | 1 | Interrupt request line |
| raised_cnt | output | CNT_W | Interrupts raised |
| skipped_cnt | output | CNT_W | Interrupts suppressed |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 64 | Write data, little-endian |
| mem_wbytes | output | 4 | Access size in bytes |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
Two operations can land in the same cycle: the interrupt raise that follows an index write, and a read-clear of the status register. The bench provokes this by pulsing `isr_rd` during the cycle that carries the index write, which comes after a combined completion-and-sync command. It then expects `isr[0]` and `irq_line` to read 1 on the next cycle. A completion and a sync offered together form a second case. For that case the bench expects back-to-back element and index writes, with the index counting the new element.

// File: rtl/uring_pkg.sv
package uring_pkg;
  localparam int FLG_W      = 16;
  localparam int IDX_W      = 16;
  localparam int ID_W       = 32;
  localparam int LEN_W      = 32;
  localparam int DATA_W     = 64;
  localparam int FLAGS_OFF  = 0;
  localparam int IDX_OFF    = 2;
  localparam int ELEM_OFF   = 4;
  localparam int ELEM_BYTES = 8;
  localparam int AVAIL_NO_INTR_BIT  = 0;
  localparam int USED_NO_NOTIFY_BIT = 0;
  localparam int ISR_QUEUE_BIT      = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ELEM, ST_IDX, ST_FRD, ST_FWAIT, ST_FWR
  } ustate_e;

  // byte offset of an element slot inside the used ring
  function automatic logic [31:0] elem_offset(input logic [31:0] slot);
    return 32'(ELEM_OFF) + slot * 32'(ELEM_BYTES);
  endfunction

  // new flag word for a notification enable/disable request
  function automatic logic [FLG_W-1:0] notify_flags(input logic [FLG_W-1:0] cur,
                                                    input logic enable);
    logic [FLG_W-1:0] r;
    r = cur;
    r[USED_NO_NOTIFY_BIT] = ~enable;
    return r;
  endfunction

  // interrupt decision after a sync
  function automatic logic irq_wanted(input logic [FLG_W-1:0] flags,
                                      input logic feat_empty,
                                      input logic is_empty);
    return !flags[AVAIL_NO_INTR_BIT] || (feat_empty && is_empty);
  endfunction
endpackage

// File: rtl/uring_cursor.sv
module uring_cursor
  import uring_pkg::*;
#(
  parameter int AW        = 32,
  parameter int RING_SIZE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [AW-1:0]    base,
  output logic [IDX_W-1:0] next_idx,
  output logic [AW-1:0]    elem_addr,
  output logic [AW-1:0]    idx_addr,
  output logic [AW-1:0]    flags_addr
);
  localparam int SLOT_W = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1;

  logic [IDX_W-1:0]  idx_q;
  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rst_n)    idx_q <= '0;
    else if (step) idx_q <= idx_q + 1'b1;
  end

  assign slot       = SLOT_W'(idx_q % IDX_W'(RING_SIZE));
  assign next_idx   = idx_q;
  assign elem_addr  = base + AW'(elem_offset(32'(slot)));
  assign idx_addr   = base + AW'(IDX_OFF);
  assign flags_addr = base + AW'(FLAGS_OFF);
endmodule

// File: rtl/uring_irq.sv
module uring_irq
  import uring_pkg::*;
#(
  parameter int ISR_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decide,
  input  logic             want,
  input  logic             isr_rd,
  output logic [ISR_W-1:0] isr,
  output logic             irq_line,
  output logic [CNT_W-1:0] raised_cnt,
  output logic [CNT_W-1:0] skipped_cnt,
  output logic             raise_evt,
  output logic             skip_evt
);
  localparam logic [ISR_W-1:0] CAUSE = ISR_W'(1) << ISR_QUEUE_BIT;

  assign raise_evt = decide && want;
  assign skip_evt  = decide && !want;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr         <= '0;
      irq_line    <= 1'b0;
      raised_cnt  <= '0;
      skipped_cnt <= '0;
    end else begin
      if (raise_evt) begin
        isr      <= isr | CAUSE;
        irq_line <= 1'b1;
      end else if (isr_rd) begin
        isr      <= '0;
        irq_line <= 1'b0;
      end
      if (raise_evt) raised_cnt  <= raised_cnt + 1'b1;
      if (skip_evt)  skipped_cnt <= skipped_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uring_complete.sv
module uring_complete
  import uring_pkg::*;
#(
  parameter int AW        = 32,
  parameter int RING_SIZE = 8,
  parameter int ISR_W     = 8,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     used_base,
  input  logic              feat_notify_empty,
  input  logic [15:0]       avail_flags,
  input  logic              queue_empty,
  output logic              cmd_ready,
  input  logic              put_valid,
  input  logic [31:0]       put_id,
  input  logic [31:0]       put_len,
  input  logic              sync_req,
  input  logic              notif_req,
  input  logic              notif_enable,
  input  logic              isr_rd,
  output logic [ISR_W-1:0]  isr,
  output logic              irq_line,
  output logic [CNT_W-1:0]  raised_cnt,
  output logic [CNT_W-1:0]  skipped_cnt,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [3:0]        mem_wbytes,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata
);
  ustate_e          st;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] len_q;
  logic             sync_pend;
  logic             en_q;
  logic [FLG_W-1:0] flg_q;

  // named internal events for the checker
  logic             elem_step;
  logic             idx_wr;
  logic             raise_evt;
  logic             skip_evt;
  logic [IDX_W-1:0] next_idx;
  logic [AW-1:0]    elem_addr, idx_addr, flags_addr;

  assign cmd_ready = (st == ST_IDLE);
  assign elem_step = (st == ST_ELEM);
  assign idx_wr    = (st == ST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      id_q      <= '0;
      len_q     <= '0;
      sync_pend <= 1'b0;
      en_q      <= 1'b0;
      flg_q     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (put_valid) begin
            id_q      <= put_id;
            len_q     <= put_len;
            sync_pend <= sync_req;
            st        <= ST_ELEM;
          end else if (sync_req) begin
            st <= ST_IDX;
          end else if (notif_req) begin
            en_q <= notif_enable;
            st   <= ST_FRD;
          end
        end
        ST_ELEM:  st <= sync_pend ? ST_IDX : ST_IDLE;
        ST_IDX:   st <= ST_IDLE;
        ST_FRD:   st <= ST_FWAIT;
        ST_FWAIT: if (mem_rvalid) begin
          flg_q <= mem_rdata;
          st    <= ST_FWR;
        end
        ST_FWR:   st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  uring_cursor #(.AW(AW), .RING_SIZE(RING_SIZE)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (elem_step),
    .base       (used_base),
    .next_idx   (next_idx),
    .elem_addr  (elem_addr),
    .idx_addr   (idx_addr),
    .flags_addr (flags_addr)
  );

  uring_irq #(.ISR_W(ISR_W), .CNT_W(CNT_W)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .decide      (idx_wr),
    .want        (irq_wanted(avail_flags, feat_notify_empty, queue_empty)),
    .isr_rd      (isr_rd),
    .isr         (isr),
    .irq_line    (irq_line),
    .raised_cnt  (raised_cnt),
    .skipped_cnt (skipped_cnt),
    .raise_evt   (raise_evt),
    .skip_evt    (skip_evt)
  );

  always_comb begin
    mem_wr     = 1'b0;
    mem_rd     = 1'b0;
    mem_addr   = flags_addr;
    mem_wdata  = '0;
    mem_wbytes = 4'd0;
    unique case (st)
      ST_ELEM: begin
        mem_wr     = 1'b1;
        mem_addr   = elem_addr;
        mem_wdata  = {len_q, id_q};
        mem_wbytes = 4'(ELEM_BYTES);
      end
      ST_IDX: begin
        mem_wr     = 1'b1;
        mem_addr   = idx_addr;
        mem_wdata  = DATA_W'(next_idx);
        mem_wbytes = 4'd2;
      end
      ST_FRD: begin
        mem_rd     = 1'b1;
        mem_wbytes = 4'd2;
      end
      ST_FWR: begin
        mem_wr     = 1'b1;
        mem_wdata  = DATA_W'(notify_flags(flg_q, en_q));
        mem_wbytes = 4'd2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uring_complete_chk.sv
module uring_complete_chk
  import uring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int ISR_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    used_base,
  input logic             cmd_ready,
  input logic             put_valid,
  input logic             isr_rd,
  input logic [ISR_W-1:0] isr,
  input logic             irq_line,
  input logic [CNT_W-1:0] raised_cnt,
  input logic [CNT_W-1:0] skipped_cnt,
  input logic             mem_wr,
  input logic             mem_rd,
  input logic [AW-1:0]    mem_addr,
  input logic [63:0]      mem_wdata,
  input logic [3:0]       mem_wbytes,
  input logic [IDX_W-1:0] next_idx,
  input logic             elem_step,
  input logic             idx_wr,
  input logic             raise_evt,
  input logic             skip_evt
);
  a_r2_put_writes: assert property (@(posedge clk) disable iff (!rst_n)
    put_valid && cmd_ready |=> mem_wr && mem_wbytes == 4'd8);

  a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    elem_step |=> next_idx == IDX_W'($past(next_idx) + 1'b1));

  a_r3_idx_write: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |-> mem_wr && mem_addr == used_base + AW'(2)
               && mem_wdata[15:0] == next_idx);

  a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
    raise_evt |=> irq_line && isr[0]
                  && raised_cnt == CNT_W'($past(raised_cnt) + 1'b1));

  a_r5_skip: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt && !isr_rd |=> $stable(isr) && $stable(irq_line)
                            && skipped_cnt == CNT_W'($past(skipped_cnt) + 1'b1));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    isr_rd && !raise_evt |=> !irq_line && isr == '0);

  a_r9_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd}));
endmodule

bind uring_complete uring_complete_chk #(.AW(AW), .ISR_W(ISR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .used_base   (used_base),
  .cmd_ready   (cmd_ready),
  .put_valid   (put_valid),
  .isr_rd      (isr_rd),
  .isr         (isr),
  .irq_line    (irq_line),
  .raised_cnt  (raised_cnt),
  .skipped_cnt (skipped_cnt),
  .mem_wr      (mem_wr),
  .mem_rd      (mem_rd),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_wbytes  (mem_wbytes),
  .next_idx    (next_idx),
  .elem_step   (elem_step),
  .idx_wr      (idx_wr),
  .raise_evt   (raise_evt),
  .skip_evt    (skip_evt)
);

// File: tb/sim_uring_complete.sv
`timescale 1ns/1ps
module sim_uring_complete;
  localparam int RS = 8;
  localparam logic [31:0] BASE = 32'h0001_0000;
  // {no_intr, feat_empty, queue_empty, expected_raise}
  localparam logic [3:0] VEC [10] = '{
    4'b0001, 4'b0111, 4'b1000, 4'b1100, 4'b1111,
    4'b1010, 4'b0011, 4'b1111, 4'b1000, 4'b0101
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat = 1'b0, qempty = 1'b0;
  logic [15:0] aflags = '0;
  logic        put_valid = 1'b0, sync_req = 1'b0, notif_req = 1'b0, notif_en = 1'b0;
  logic        isr_rd = 1'b0;
  logic [31:0] put_id = '0, put_len = '0;
  logic        cmd_ready, irq_line, mem_wr, mem_rd, mem_rvalid;
  logic [7:0]  isr;
  logic [15:0] raised_cnt, skipped_cnt, mem_rdata, mflags;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [3:0]  mem_wbytes;

  int n_chk = 0, n_fail = 0;
  int m_raised = 0, m_skipped = 0, m_idx = 0;
  logic m_line = 1'b0;
  bit finished = 0;

  always #10 clk = ~clk;

  uring_complete u0 (
    .clk(clk), .rst_n(rst_n), .used_base(BASE), .feat_notify_empty(feat),
    .avail_flags(aflags), .queue_empty(qempty), .cmd_ready(cmd_ready),
    .put_valid(put_valid), .put_id(put_id), .put_len(put_len),
    .sync_req(sync_req), .notif_req(notif_req), .notif_enable(notif_en),
    .isr_rd(isr_rd), .isr(isr), .irq_line(irq_line),
    .raised_cnt(raised_cnt), .skipped_cnt(skipped_cnt),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wbytes(mem_wbytes),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: read answered one cycle after the strobe
  always @(posedge clk) begin
    mem_rvalid <= mem_rd;
    mem_rdata  <= mflags;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_elem(input string req, input logic [31:0] id, input logic [31:0] len);
    logic [31:0] ea;
    ea = BASE + 32'd4 + 32'd8 * 32'(m_idx % RS);
    chk(mem_wr && mem_wbytes == 4'd8, {req, " elem strobe"}, {mem_wr, mem_wbytes}, {1'b1, 4'd8});
    chk(mem_addr == ea, {req, " elem addr"}, mem_addr, ea);
    chk(mem_wdata == {len, id}, {req, " elem data"}, mem_wdata, {len, id});
    m_idx++;
  endtask

  task automatic check_idx(input string req);
    chk(mem_wr && mem_wbytes == 4'd2 && mem_addr == BASE + 32'd2,
        {req, " idx write"}, mem_addr, BASE + 32'd2);
    chk(mem_wdata == 64'(m_idx), {req, " idx value"}, mem_wdata, 64'(m_idx));
  endtask

  task automatic check_irq(input string req);
    chk(irq_line == m_line && isr[0] == m_line, {req, " irq"}, {isr, irq_line}, {7'd0, m_line, m_line});
    chk(raised_cnt == 16'(m_raised) && skipped_cnt == 16'(m_skipped),
        {req, " counters"}, {raised_cnt, skipped_cnt}, {16'(m_raised), 16'(m_skipped)});
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    mflags = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !irq_line && isr == 0 && !mem_wr && !mem_rd && raised_cnt == 0
        && skipped_cnt == 0, "R1 reset", {cmd_ready, irq_line, mem_wr, mem_rd}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !mem_wr && !mem_rd, "R1 idle after reset", {cmd_ready, mem_wr}, 2'b10);

    // table walk: put, sync, decision, optional clear
    for (int i = 0; i < 10; i++) begin
      logic [31:0] id, len;
      id = 32'hA000_0000 + 32'(i);
      len = 32'(100 * i + 7);
      aflags = 16'h0100 | 16'(VEC[i][3]);
      feat = VEC[i][2];
      qempty = VEC[i][1];
      put_valid = 1'b1; put_id = id; put_len = len;
      step();
      put_valid = 1'b0;
      check_elem("R2", id, len);
      step();
      chk(!mem_wr, "R3 no index write on put alone", 64'(mem_wr), 64'd0);
      sync_req = 1'b1;
      step();
      sync_req = 1'b0;
      check_idx("R3");
      step();
      if (VEC[i][0]) begin m_raised++; m_line = 1'b1; end
      else m_skipped++;
      check_irq(VEC[i][0] ? "R4" : "R5");
      if (i % 2 == 1) begin
        isr_rd = 1'b1;
        step();
        isr_rd = 1'b0;
        m_line = 1'b0;
        check_irq("R6 clear");
      end
    end

    // R7: put and sync together; R6: clear coincides with raise; R9: busy
    aflags = 16'h0000; feat = 1'b0; qempty = 1'b0;
    put_valid = 1'b1; sync_req = 1'b1; put_id = 32'h0000_BEEF; put_len = 32'd64;
    step();
    sync_req = 1'b0;
    put_id = 32'hDEAD_0000;
    check_elem("R7", 32'h0000_BEEF, 32'd64);
    chk(!cmd_ready, "R9 busy during sequence", 64'(cmd_ready), 64'd0);
    step();
    put_valid = 1'b0;
    check_idx("R7");
    isr_rd = 1'b1;
    step();
    isr_rd = 1'b0;
    m_raised++; m_line = 1'b1;
    check_irq("R6 raise wins");
    chk(!mem_wr && cmd_ready, "R9 put while busy ignored", {mem_wr, cmd_ready}, 2'b01);
    isr_rd = 1'b1;
    step();
    isr_rd = 1'b0;
    m_line = 1'b0;
    check_irq("R6 clear after");

    // R8: enable notifications
    mflags = 16'h8041;
    notif_req = 1'b1; notif_en = 1'b1;
    step();
    notif_req = 1'b0;
    chk(mem_rd && !mem_wr && mem_addr == BASE && !cmd_ready, "R8 flag read", mem_addr, BASE);
    step();
    step();
    chk(mem_wr && mem_wbytes == 4'd2 && mem_addr == BASE, "R8 flag write", mem_addr, BASE);
    chk(mem_wdata[15:0] == 16'h8040, "R8 enable clears bit0", mem_wdata, 64'h8040);
    step();
    // R8: disable notifications
    mflags = 16'h2200;
    notif_req = 1'b1; notif_en = 1'b0;
    step();
    notif_req = 1'b0;
    step();
    step();
    chk(mem_wr && mem_wdata[15:0] == 16'h2201, "R8 disable sets bit0", mem_wdata, 64'h2201);
    step();

    // R9: notify offered with a completion is ignored
    put_valid = 1'b1; notif_req = 1'b1; put_id = 32'h1234_5678; put_len = 32'd9;
    step();
    put_valid = 1'b0; notif_req = 1'b0;
    check_elem("R9", 32'h1234_5678, 32'd9);
    step();
    chk(!mem_rd && !mem_wr && cmd_ready, "R9 notify ignored", {mem_rd, mem_wr}, 2'b00);
    step();
    chk(!mem_rd, "R9 no late read", 64'(mem_rd), 64'd0);

    // final sync with suppression (R5) and index count (R3)
    aflags = 16'h0001; feat = 1'b1; qempty = 1'b0;
    sync_req = 1'b1;
    step();
    sync_req = 1'b0;
    check_idx("R3 final");
    step();
    m_skipped++;
    check_irq("R5 final");

    finish_up();
  end
endmodule